// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers eight level-sensitive PCI interrupt requests (PIRQ A to H) and one ACPI system control interrupt (SCI) onto two sets of interrupt controller inputs: sixteen legacy PIC lines and twenty-four APIC global system interrupt (GSI) lines. On the PIC side any number of PIRQs may share a line. Each PIC output is the OR of every enabled PIRQ programmed to it, plus the SCI when the SCI is steered there. On the APIC side every PIRQ owns a fixed GSI line of its own (16 + n). The SCI is ORed onto whichever line its select code names.

Software programs eight route bytes and one ACPI control byte through a simple write-only register port. The route bytes sit in two banks of four: addresses 0 to 3 serve PIRQ A to D and addresses 4 to 7 serve PIRQ E to H. The ACPI control byte sits at address 8. All outputs are combinational in the current request levels and the stored registers.

A query port reports, for any one PIRQ, where it currently lands: on a PIC line, on its GSI, or nowhere. A one-cycle routing-changed pulse tells the surrounding fabric that a route byte was written, so that it can refresh any cached copy of these answers.

Top module: `pirq_irq_router`

## Requirements
- R1: A write with address 0..7 stores the byte as the route byte of PIRQ n = address (0..3 PIRQ A..D, 4..7 PIRQ E..H). A write with address 8 stores the ACPI control byte. Writes to addresses 9..15 change nothing. A stored value governs the outputs from the cycle after the write edge.
- R2: In a route byte, bits 4:0 give the PIC line number and bit 7 set disables PIC routing of that PIRQ. Bits 6:5 are ignored.
- R3: PIC line k is high exactly when some PIRQ is high whose route byte has bit 7 clear and line number k, or when the SCI is high and mapped to k. Several PIRQs may share one line.
- R4: An enabled route byte with a line number of 16..31 drives no PIC line.
- R5: GSI line 16 + n follows PIRQ n whatever its route byte holds. No other PIRQ drives that line.
- R6: ACPI control bits 2:0 select the SCI target: code 0 gives 9, 1 gives 10, 2 gives 11, 4 gives 20, 5 gives 21. Codes 3, 6 and 7 disconnect the SCI. Bits 7:3 are ignored.
- R7: The SCI level is ORed onto the GSI line of its target number. It is also ORed onto the PIC line of the same number only when the target is below 16.
- R8: For the PIRQ on qry_pirq, qry_kind is 1 (PIC) with qry_irq = line number for an enabled route below 16. It is 0 (none) with qry_irq = 0 for an enabled route of 16 or more. It is 2 (GSI) with qry_irq = 16 + pirq when bit 7 is set. Code 3 never appears.
- R9: route_changed is high for exactly the one cycle after each write edge to addresses 0..7. Writes to address 8 or above do not raise it.
- R10: Synchronous active-low reset sets every route byte to 0x80, sets the SCI select code to 0 and clears route_changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0..7 route bytes, 8 ACPI control) |
| reg_wdata | input | 8 | Register write data |
| pirq_lvl | input | 8 | PIRQ A..H request levels (bit n = PIRQ n) |
| sci_lvl | input | 1 | ACPI SCI level |
| qry_pirq | input | 3 | PIRQ index for the route query |
| pic_irq | output | 16 | Legacy PIC input levels |
| gsi_irq | output | 24 | APIC GSI levels |
| route_changed | output | 1 | One-cycle pulse after a route byte write |
| qry_kind | output | 2 | Query result: 0 none, 1 PIC, 2 GSI |
| qry_irq | output | 5 | Query result line number |

## Verification
A corrupted route byte or SCI code shows at once: the wrong PIC or GSI line rises in the same cycle a matching request is high, and the query port reports a wrong kind or number in the same cycle the bad PIRQ is selected. A write that lands in the wrong slot, or a stale value held after reset, shows on the very next cycle. A lost or extra routing-changed pulse also shows on the very next cycle. The bench therefore compares every output against its model on every clock. It sweeps the query index and the SCI codes so that no stored field stays unobserved for long.

// File: rtl/pirq_rt_pkg.sv
// Package: shared encodings for the PIRQ router.
// Assumes: GSI numbers fit in 5 bits; the SCI select field is 3 bits wide.
package pirq_rt_pkg;

    typedef enum logic [1:0] {
        QRY_NONE = 2'd0,
        QRY_PIC  = 2'd1,
        QRY_GSI  = 2'd2
    } qry_kind_e;

    localparam int SCI_CODE_W = 3;
    localparam int IRQ_NUM_W  = 5;

    // Map an SCI select code to its target line; valid low means disconnected.
    function automatic logic [IRQ_NUM_W:0] sci_target(input logic [SCI_CODE_W-1:0] code);
        logic [IRQ_NUM_W:0] r;
        case (code)
            3'd0:    r = {1'b1, 5'd9};
            3'd1:    r = {1'b1, 5'd10};
            3'd2:    r = {1'b1, 5'd11};
            3'd4:    r = {1'b1, 5'd20};
            3'd5:    r = {1'b1, 5'd21};
            default: r = {1'b0, 5'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
// Module: route register file. Holds one line-select field and one disable
// flag per PIRQ plus the SCI select code, and pulses route_changed once after
// any route byte write.
// Assumes: route bytes at addresses 0..NUM_PIRQ-1, ACPI control at NUM_PIRQ.
module pirq_route_regs #(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4,
    parameter int SEL_W    = 5,
    parameter int DIS_BIT  = 7,
    parameter int CODE_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [SEL_W-1:0]     route_sel [NUM_PIRQ],
    output logic [NUM_PIRQ-1:0]  route_dis,
    output logic [CODE_W-1:0]    sci_code,
    output logic                 route_changed
);
    localparam logic [ADDR_W-1:0] ACPI_ADDR = ADDR_W'(NUM_PIRQ);

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[DIS_BIT-1:SEL_W];

    genvar n;
    generate
        for (n = 0; n < NUM_PIRQ; n++) begin : g_route
            // Store the select field and disable flag of PIRQ n.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    route_sel[n] <= '0;
                    route_dis[n] <= 1'b1;
                end else if (reg_we && reg_addr == ADDR_W'(n)) begin
                    route_sel[n] <= reg_wdata[SEL_W-1:0];
                    route_dis[n] <= reg_wdata[DIS_BIT];
                end
            end
        end
    endgenerate

    // Store the SCI select code from the ACPI control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_code <= '0;
        else if (reg_we && reg_addr == ACPI_ADDR)
            sci_code <= reg_wdata[CODE_W-1:0];
    end

    // Pulse once after any write into either route bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_changed <= 1'b0;
        else
            route_changed <= reg_we && (reg_addr < ACPI_ADDR);
    end

endmodule

// File: rtl/pirq_sci_decode.sv
// Module: SCI target decode. Turns the select code into a one-hot vector over
// all GSI numbers, gated by the SCI level.
// Assumes: target numbers below GSI_LINES.
module pirq_sci_decode #(
    parameter int GSI_LINES = 24,
    parameter int CODE_W    = 3
) (
    input  logic [CODE_W-1:0]    sci_code,
    input  logic                 sci_lvl,
    output logic [GSI_LINES-1:0] sci_vec
);
    import pirq_rt_pkg::*;

    logic [IRQ_NUM_W:0] tgt;

    // Raise the bit of the selected line while the SCI is high.
    always_comb begin
        tgt     = sci_target(sci_code);
        sci_vec = '0;
        for (int k = 0; k < GSI_LINES; k++)
            if (tgt[IRQ_NUM_W] && tgt[IRQ_NUM_W-1:0] == IRQ_NUM_W'(k))
                sci_vec[k] = sci_lvl;
    end

endmodule

// File: rtl/pirq_pic_mux.sv
// Module: PIC wired-OR network. Each PIC line collects every enabled PIRQ
// that selects it plus the SCI contribution for that line.
// Assumes: select values at or above PIC_LINES match no line.
module pirq_pic_mux #(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16,
    parameter int SEL_W     = 5
) (
    input  logic [NUM_PIRQ-1:0]  pirq_lvl,
    input  logic [SEL_W-1:0]     route_sel [NUM_PIRQ],
    input  logic [NUM_PIRQ-1:0]  route_dis,
    input  logic [PIC_LINES-1:0] sci_pic,
    output logic [PIC_LINES-1:0] pic_irq
);
    genvar k;
    generate
        for (k = 0; k < PIC_LINES; k++) begin : g_line
            // OR together all sources steered to PIC line k.
            always_comb begin
                pic_irq[k] = sci_pic[k];
                for (int n = 0; n < NUM_PIRQ; n++)
                    if (!route_dis[n] && route_sel[n] == SEL_W'(k))
                        pic_irq[k] = pic_irq[k] | pirq_lvl[n];
            end
        end
    endgenerate

endmodule

// File: rtl/pirq_route_query.sv
// Module: route query. Reports where one PIRQ currently lands.
// Assumes: GSI of PIRQ n is PIC_LINES + n.
module pirq_route_query #(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16,
    parameter int SEL_W     = 5,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0]     qry_pirq,
    input  logic [SEL_W-1:0]     route_sel [NUM_PIRQ],
    input  logic [NUM_PIRQ-1:0]  route_dis,
    output logic [1:0]           qry_kind,
    output logic [4:0]           qry_irq
);
    import pirq_rt_pkg::*;

    logic [SEL_W-1:0] sel;
    logic             dis;

    // Select the addressed route and classify it.
    always_comb begin
        sel = '0;
        dis = 1'b0;
        for (int n = 0; n < NUM_PIRQ; n++)
            if (qry_pirq == IDX_W'(n)) begin
                sel = route_sel[n];
                dis = route_dis[n];
            end
        if (dis) begin
            qry_kind = QRY_GSI;
            qry_irq  = 5'(PIC_LINES) + 5'(qry_pirq);
        end else if (32'(sel) < PIC_LINES) begin
            qry_kind = QRY_PIC;
            qry_irq  = 5'(sel);
        end else begin
            qry_kind = QRY_NONE;
            qry_irq  = '0;
        end
    end

endmodule

// File: rtl/pirq_irq_router.sv
// Module: top of the PIRQ router. Wires the register file, SCI decode,
// PIC OR network, fixed APIC mapping and the query port together.
// Assumes: GSI_LINES >= PIC_LINES + NUM_PIRQ.
module pirq_irq_router #(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16,
    parameter int GSI_LINES = 24,
    parameter int ADDR_W    = 4,
    parameter int SEL_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [NUM_PIRQ-1:0]  pirq_lvl,
    input  logic                 sci_lvl,
    input  logic [$clog2(NUM_PIRQ)-1:0] qry_pirq,
    output logic [PIC_LINES-1:0] pic_irq,
    output logic [GSI_LINES-1:0] gsi_irq,
    output logic                 route_changed,
    output logic [1:0]           qry_kind,
    output logic [4:0]           qry_irq
);
    import pirq_rt_pkg::*;

    localparam int IDX_W = $clog2(NUM_PIRQ);

    logic [SEL_W-1:0]      route_sel [NUM_PIRQ];
    logic [NUM_PIRQ-1:0]   route_dis;
    logic [SCI_CODE_W-1:0] sci_code;
    logic [GSI_LINES-1:0]  sci_vec;

    pirq_route_regs #(
        .NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
        .DIS_BIT(7), .CODE_W(SCI_CODE_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .route_sel(route_sel), .route_dis(route_dis),
        .sci_code(sci_code), .route_changed(route_changed)
    );

    pirq_sci_decode #(
        .GSI_LINES(GSI_LINES), .CODE_W(SCI_CODE_W)
    ) sci_i (
        .sci_code(sci_code), .sci_lvl(sci_lvl), .sci_vec(sci_vec)
    );

    pirq_pic_mux #(
        .NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES), .SEL_W(SEL_W)
    ) pic_i (
        .pirq_lvl(pirq_lvl), .route_sel(route_sel), .route_dis(route_dis),
        .sci_pic(sci_vec[PIC_LINES-1:0]), .pic_irq(pic_irq)
    );

    pirq_route_query #(
        .NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES), .SEL_W(SEL_W), .IDX_W(IDX_W)
    ) qry_i (
        .qry_pirq(qry_pirq), .route_sel(route_sel), .route_dis(route_dis),
        .qry_kind(qry_kind), .qry_irq(qry_irq)
    );

    genvar g;
    generate
        for (g = 0; g < GSI_LINES; g++) begin : g_gsi
            if (g >= PIC_LINES && g < PIC_LINES + NUM_PIRQ) begin : g_pirq
                // GSI line owned by one PIRQ, plus any SCI on it.
                assign gsi_irq[g] = pirq_lvl[g-PIC_LINES] | sci_vec[g];
            end else begin : g_sci
                // GSI line reachable only by the SCI.
                assign gsi_irq[g] = sci_vec[g];
            end
        end
    endgenerate

endmodule

// File: rtl/pirq_router_chk.sv
// Module: assertion checker for the PIRQ router, bound to the top.
// Assumes: default parameters of the top (8 PIRQs, 16 PIC, 24 GSI).
module pirq_router_chk #(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16,
    parameter int GSI_LINES = 24,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [NUM_PIRQ-1:0]  pirq_lvl,
    input logic                 sci_lvl,
    input logic [PIC_LINES-1:0] pic_irq,
    input logic [GSI_LINES-1:0] gsi_irq,
    input logic                 route_changed,
    input logic [1:0]           qry_kind,
    input logic [4:0]           qry_irq
);
    localparam logic [ADDR_W-1:0] ACPI_ADDR = ADDR_W'(NUM_PIRQ);

    p_notify_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr < ACPI_ADDR) |=> route_changed);

    p_no_notify_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr < ACPI_ADDR) |=> !route_changed);

    p_pic_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|pic_irq) |-> (sci_lvl || (|pirq_lvl)));

    p_qry_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        qry_kind != 2'd3);

    p_qry_gsi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_kind == 2'd2) |-> (qry_irq >= 5'(PIC_LINES)));

    p_reset_routes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (pic_irq[PIC_LINES-1:10] == '0 && pic_irq[8:0] == '0));

    p_sci_low_gsi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gsi_irq[PIC_LINES-1:0]) |-> sci_lvl);

    genvar n;
    generate
        for (n = 0; n < NUM_PIRQ; n++) begin : g_chk
            p_gsi_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pirq_lvl[n] |-> gsi_irq[PIC_LINES+n]);
        end
    endgenerate

endmodule

bind pirq_irq_router pirq_router_chk #(
    .NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES), .GSI_LINES(GSI_LINES), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl), .pic_irq(pic_irq), .gsi_irq(gsi_irq),
    .route_changed(route_changed), .qry_kind(qry_kind), .qry_irq(qry_irq)
);

// File: tb/pirq_irq_router_tb.sv
// Bench: behavioural reference model of the router, compared on every clock.
module pirq_irq_router_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  pirq_lvl = '0;
    logic        sci_lvl = 1'b0;
    logic [2:0]  qry_pirq = '0;
    logic [15:0] pic_irq;
    logic [23:0] gsi_irq;
    logic        route_changed;
    logic [1:0]  qry_kind;
    logic [4:0]  qry_irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R10";

    // model state
    logic [7:0] m_route [8];
    int         m_code = 0;
    logic       m_chg = 1'b0;

    pirq_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
        .qry_pirq(qry_pirq), .pic_irq(pic_irq), .gsi_irq(gsi_irq),
        .route_changed(route_changed), .qry_kind(qry_kind), .qry_irq(qry_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sci_num(int code);
        case (code)
            0: return 9;
            1: return 10;
            2: return 11;
            4: return 20;
            5: return 21;
            default: return -1;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [15:0] e_pic;
        logic [23:0] e_gsi;
        int          s;
        logic [7:0]  b;
        int          e_kind;
        int          e_irq;
        e_pic = '0;
        e_gsi = '0;
        s = sci_num(m_code);
        for (int k = 0; k < 24; k++) begin
            if (sci_lvl && s == k) e_gsi[k] = 1'b1;
            if (k >= 16 && pirq_lvl[k-16]) e_gsi[k] = 1'b1;
        end
        for (int k = 0; k < 16; k++) begin
            if (sci_lvl && s == k) e_pic[k] = 1'b1;
            for (int n = 0; n < 8; n++)
                if (!m_route[n][7] && int'(m_route[n][4:0]) == k && pirq_lvl[n])
                    e_pic[k] = 1'b1;
        end
        b = m_route[qry_pirq];
        if (b[7]) begin e_kind = 2; e_irq = 16 + int'(qry_pirq); end
        else if (b[4:0] < 5'd16) begin e_kind = 1; e_irq = int'(b[4:0]); end
        else begin e_kind = 0; e_irq = 0; end
        check("pic_irq", 32'(pic_irq), 32'(e_pic));
        check("gsi_irq", 32'(gsi_irq), 32'(e_gsi));
        check("route_changed", 32'(route_changed), 32'(m_chg));
        check("qry_kind", 32'(qry_kind), 32'(e_kind));
        check("qry_irq", 32'(qry_irq), 32'(e_irq));
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) begin
            for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
            m_code = 0;
            m_chg  = 1'b0;
        end else begin
            m_chg = reg_we && reg_addr < 4'd8;
            if (reg_we && reg_addr < 4'd8) m_route[reg_addr[2:0]] = reg_wdata;
            else if (reg_we && reg_addr == 4'd8) m_code = int'(reg_wdata[2:0]);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic idle(int cnt);
        for (int i = 0; i < cnt; i++) cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state, even with every request and the SCI high
        pirq_lvl = 8'hFF; sci_lvl = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        for (int q = 0; q < 8; q++) begin qry_pirq = 3'(q); cyc(); end

        // R1 and R2: program both banks, bits 6:5 junk, sweep requests
        cur_req = "R1";
        pirq_lvl = '0; sci_lvl = 1'b0;
        for (int n = 0; n < 8; n++) wr(4'(n), 8'h60 | 8'(n + 2));
        for (int n = 0; n < 8; n++) begin pirq_lvl = 8'(1 << n); qry_pirq = 3'(n); cyc(); end
        cur_req = "R2";
        wr(4'd3, 8'hE5);
        pirq_lvl = 8'h08; qry_pirq = 3'd3; cyc();
        wr(4'd3, 8'h25); cyc();
        cur_req = "R1";
        for (int a = 9; a < 16; a++) wr(4'(a), 8'h84);
        pirq_lvl = 8'hFF; idle(2);

        // R3: shared lines
        cur_req = "R3";
        wr(4'd0, 8'h05); wr(4'd4, 8'h05); wr(4'd7, 8'h05);
        pirq_lvl = 8'h01; cyc(); pirq_lvl = 8'h90; cyc(); pirq_lvl = 8'h00; cyc();

        // R4: enabled lines 16 and 31
        cur_req = "R4";
        wr(4'd1, 8'h10); wr(4'd2, 8'h1F);
        pirq_lvl = 8'h06; qry_pirq = 3'd1; cyc(); qry_pirq = 3'd2; cyc();
        wr(4'd1, 8'h0F); cyc();

        // R5: GSI follows request regardless of route byte
        cur_req = "R5";
        for (int n = 0; n < 8; n++) begin pirq_lvl = 8'(8'hA5 >> n); cyc(); end

        // R6 and R7: every SCI code, junk in upper bits
        cur_req = "R6";
        pirq_lvl = '0;
        for (int c = 0; c < 8; c++) begin
            wr(4'd8, 8'hF8 | 8'(c));
            cur_req = "R7";
            sci_lvl = 1'b1; cyc(); sci_lvl = 1'b0; cyc();
            wr(4'd0, 8'h0A); sci_lvl = 1'b1; pirq_lvl = 8'h01; cyc();
            pirq_lvl = '0; sci_lvl = 1'b0;
            cur_req = "R6";
        end
        wr(4'd8, 8'h00);

        // R8: query sweep over mixed routes
        cur_req = "R8";
        wr(4'd5, 8'h80); wr(4'd6, 8'h14); wr(4'd0, 8'h00);
        for (int q = 0; q < 8; q++) begin qry_pirq = 3'(q); cyc(); end

        // R9: notification after bank writes only
        cur_req = "R9";
        wr(4'd7, 8'h83); idle(1);
        wr(4'd8, 8'h01); idle(1);
        wr(4'd12, 8'h01); idle(1);
        wr(4'd2, 8'h03); wr(4'd6, 8'h03); idle(1);

        // Random traffic covering all requirements together
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            reg_we = ($urandom % 3) == 0;
            reg_addr = 4'($urandom % 12);
            reg_wdata = 8'($urandom);
            pirq_lvl = 8'($urandom);
            sci_lvl = 1'($urandom);
            qry_pirq = 3'($urandom);
            cyc();
        end
        reg_we = 1'b0;

        // R10: reset again restores defaults
        cur_req = "R10";
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        pirq_lvl = 8'hFF; sci_lvl = 1'b1; idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule